// File: doc/BRIEF.md
# Binary Calendar Time Counter

This block keeps wall-clock time and a calendar in plain binary fields: seconds, minutes and hours in 24-hour form, day of month, month, a two-digit year, and a day-of-week index. It advances once for each cycle on which the one-pulse-per-second `tick` input is high. Carries ripple through the fields within that same cycle. Day-of-month length follows the month. February gets a 29th day whenever the year is a multiple of four.

A register-style write port loads any single field in one cycle. It has no back-pressure: there is no ready signal, every write is accepted on the cycle it is presented, and no write can be refused or delayed. Reset models a total power loss. Every field returns to its default and the counter stays frozen, ignoring ticks, until the first write to any field. The `frozen` output reports this condition so that software can tell the time is not valid.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields read 0 seconds, 0 minutes, 0 hours, day 1, month 1, year 0, weekday 0, and `frozen` is 1.
- R2: While `frozen` is 1, ticks change no field.
- R3: A write with `wr_en`=1 and `wr_sel` in 0..6 loads `wr_data`, masked to the field width, into the selected field on the next clock edge. The select encoding is 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday. The same write clears `frozen` from the next cycle on. A tick in that same cycle does not advance a frozen counter, and counting starts with the next tick.
- R4: On a running tick, seconds at 59 or above wrap to 0 and carry into minutes. Minutes at 59 or above wrap to 0 and carry into hours. Hours at 23 or above wrap to 0 and carry into the day.
- R5: Day of month wraps to 1, and carries into the month, when it is at or above the month's length. The length is 30 for months 4, 6, 9 and 11, 28 or 29 for month 2, and 31 for every other month value.
- R6: February has 29 days when the year modulo 4 is 0, year 0 included. Otherwise it has 28.
- R7: Month at 12 or above wraps to 1 and carries into the year. Year at 99 or above wraps to 0.
- R8: Weekday advances on the same tick as the day of month and wraps from 6 to 0.
- R9: If a write and a running tick fall in the same cycle, the written field takes the written value. All other fields advance as the tick dictates, and carries are computed from the field values before the write.
- R10: A write with `wr_sel`=7 has no effect on any field or on `frozen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models total power loss |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select (0 sec .. 6 weekday, 7 none) |
| wr_data | input | 7 | Write value |
| sec | output | 6 | Seconds 0..59 |
| min | output | 6 | Minutes 0..59 |
| hour | output | 5 | Hours 0..23 |
| day | output | 5 | Day of month 1..31 |
| month | output | 4 | Month 1..12 |
| year | output | 7 | Year 0..99 |
| wday | output | 3 | Day of week 0..6 |
| frozen | output | 1 | Counter held after cold start |

## Verification
A field write and a tick can land in the same cycle. This matters most when the tick carries out of the very field being written, or out of a lower field into it. The bench provokes the collision directly by writing seconds as 59 rolls over. It also produces random collisions by raising writes and ticks independently on each cycle. A bench model applies the tick from the pre-write values and then overrides the selected field, and every output is compared against that model after each edge. The freeze release is a second collision: a write and a tick on the same cycle after reset must load the field without advancing it.

// File: rtl/cal_time_pkg.sv
package cal_time_pkg;
  localparam int W_SEC   = 6;
  localparam int W_MIN   = 6;
  localparam int W_HOUR  = 5;
  localparam int W_DAY   = 5;
  localparam int W_MONTH = 4;
  localparam int W_YEAR  = 7;
  localparam int W_WDAY  = 3;
  localparam int W_DATA  = 7;
  localparam int N_FIELD = 7;

  typedef enum logic [2:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DAY   = 3'd3,
    F_MONTH = 3'd4,
    F_YEAR  = 3'd5,
    F_WDAY  = 3'd6,
    F_NONE  = 3'd7
  } field_e;
endpackage

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter #(
  parameter int W    = 6,
  parameter int MINV = 0,
  parameter int RSTV = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [W-1:0] limit,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] MIN_L = W'(MINV);
  localparam logic [W-1:0] RST_L = W'(RSTV);

  logic at_top;
  logic [W-1:0] q_n;

  assign at_top = (q >= limit);
  assign wrap   = inc && at_top;

  always_comb begin
    q_n = q;
    if (wr)       q_n = wdata;
    else if (inc) q_n = at_top ? MIN_L : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_L;
    else        q <= q_n;
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_time_pkg::*;
(
  input  logic [W_MONTH-1:0] month,
  input  logic [W_YEAR-1:0]  year,
  output logic [W_DAY-1:0]   dim
);
  logic leap;
  assign leap = (year[1:0] == 2'b00);

  always_comb begin
    case (month)
      4'd2:                      dim = leap ? W_DAY'(29) : W_DAY'(28);
      4'd4, 4'd6, 4'd9, 4'd11:   dim = W_DAY'(30);
      default:                   dim = W_DAY'(31);
    endcase
  end
endmodule

// File: rtl/cal_cold_gate.sv
module cal_cold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic any_wr,
  output logic run,
  output logic frozen
);
  assign run = tick && !frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frozen <= 1'b1;
    else if (any_wr) frozen <= 1'b0;
  end
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_time_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [W_DATA-1:0]  wr_data,
  output logic [W_SEC-1:0]   sec,
  output logic [W_MIN-1:0]   min,
  output logic [W_HOUR-1:0]  hour,
  output logic [W_DAY-1:0]   day,
  output logic [W_MONTH-1:0] month,
  output logic [W_YEAR-1:0]  year,
  output logic [W_WDAY-1:0]  wday,
  output logic               frozen
);
  logic [N_FIELD-1:0] hit;
  logic run;
  logic c_sec, c_min, c_hour, c_day, c_month, c_year, c_wday;
  logic [W_DAY-1:0] dim;

  for (genvar i = 0; i < N_FIELD; i++) begin : g_dec
    assign hit[i] = wr_en && (wr_sel == 3'(i));
  end

  cal_cold_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .any_wr(|hit),
    .run(run), .frozen(frozen)
  );

  cal_month_len u_mlen (.month(month), .year(year), .dim(dim));

  cal_wrap_counter #(.W(W_SEC), .MINV(0), .RSTV(0)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(run), .limit(W_SEC'(59)),
    .wr(hit[F_SEC]), .wdata(wr_data[W_SEC-1:0]), .q(sec), .wrap(c_sec)
  );
  cal_wrap_counter #(.W(W_MIN), .MINV(0), .RSTV(0)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .limit(W_MIN'(59)),
    .wr(hit[F_MIN]), .wdata(wr_data[W_MIN-1:0]), .q(min), .wrap(c_min)
  );
  cal_wrap_counter #(.W(W_HOUR), .MINV(0), .RSTV(0)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .limit(W_HOUR'(23)),
    .wr(hit[F_HOUR]), .wdata(wr_data[W_HOUR-1:0]), .q(hour), .wrap(c_hour)
  );
  cal_wrap_counter #(.W(W_DAY), .MINV(1), .RSTV(1)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .limit(dim),
    .wr(hit[F_DAY]), .wdata(wr_data[W_DAY-1:0]), .q(day), .wrap(c_day)
  );
  cal_wrap_counter #(.W(W_WDAY), .MINV(0), .RSTV(0)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .limit(W_WDAY'(6)),
    .wr(hit[F_WDAY]), .wdata(wr_data[W_WDAY-1:0]), .q(wday), .wrap(c_wday)
  );
  cal_wrap_counter #(.W(W_MONTH), .MINV(1), .RSTV(1)) u_month (
    .clk(clk), .rst_n(rst_n), .inc(c_day), .limit(W_MONTH'(12)),
    .wr(hit[F_MONTH]), .wdata(wr_data[W_MONTH-1:0]), .q(month), .wrap(c_month)
  );
  cal_wrap_counter #(.W(W_YEAR), .MINV(0), .RSTV(0)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_month), .limit(W_YEAR'(99)),
    .wr(hit[F_YEAR]), .wdata(wr_data[W_YEAR-1:0]), .q(year), .wrap(c_year)
  );

  logic unused_carry;
  assign unused_carry = c_year ^ c_wday;
endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [6:0] wr_data,
  input logic [5:0] sec,
  input logic [5:0] min,
  input logic [4:0] hour,
  input logic [4:0] day,
  input logic [3:0] month,
  input logic [6:0] year,
  input logic [2:0] wday,
  input logic       frozen
);
  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
      $stable(day) && $stable(month) && $stable(year) && $stable(wday)));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && wr_en && wr_sel != 3'd7) |=> !frozen);

  p_stay_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |=> !frozen);

  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frozen && !wr_en && sec >= 6'd59) |=> (sec == 6'd0 && min != $past(min)));

  p_wday_with_day_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frozen && !wr_en && sec >= 6'd59 && min >= 6'd59 && hour >= 5'd23)
      |=> (wday != $past(wday) && day != $past(day)));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> sec == $past(wr_data[5:0]));

  p_sel_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd7 && !tick) |=> ($stable(frozen) && $stable(sec) &&
      $stable(min) && $stable(hour) && $stable(day) && $stable(month) &&
      $stable(year) && $stable(wday)));
endmodule

bind cal_time_counter cal_time_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .day(day),
  .month(month), .year(year), .wday(wday), .frozen(frozen)
);

// File: tb/tb_cal_time_counter.sv
module tb_cal_time_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd7;
  logic [6:0] wr_data = 7'd0;
  logic [5:0] sec;
  logic [5:0] min;
  logic [4:0] hour;
  logic [4:0] day;
  logic [3:0] month;
  logic [6:0] year;
  logic [2:0] wday;
  logic frozen;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_sec, m_min, m_hour, m_day, m_month, m_year, m_wday;
  bit m_frozen;

  always #5 clk = ~clk;

  cal_time_counter dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .day(day),
    .month(month), .year(year), .wday(wday), .frozen(frozen)
  );

  function automatic int month_days(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int pack_state();
    return m_sec | (m_min << 6) | (m_hour << 12) | (m_day << 17) |
           (m_month << 22) | (m_year << 26);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit t, input bit w, input int s, input int d);
    bit run, c0, c1, c2, c3, c4;
    int dim;
    run = t && !m_frozen;
    dim = month_days(m_month, m_year);
    c0 = run && (m_sec >= 59);
    c1 = c0 && (m_min >= 59);
    c2 = c1 && (m_hour >= 23);
    c3 = c2 && (m_day >= dim);
    c4 = c3 && (m_month >= 12);
    if (run) m_sec = c0 ? 0 : m_sec + 1;
    if (c0) m_min = c1 ? 0 : m_min + 1;
    if (c1) m_hour = c2 ? 0 : m_hour + 1;
    if (c2) begin
      m_day = c3 ? 1 : m_day + 1;
      m_wday = (m_wday >= 6) ? 0 : m_wday + 1;
    end
    if (c3) m_month = c4 ? 1 : m_month + 1;
    if (c4) m_year = (m_year >= 99) ? 0 : m_year + 1;
    if (w && s != 7) begin
      m_frozen = 1'b0;
      case (s)
        0: m_sec = d & 63;
        1: m_min = d & 63;
        2: m_hour = d & 31;
        3: m_day = d & 31;
        4: m_month = d & 15;
        5: m_year = d & 127;
        default: m_wday = d & 7;
      endcase
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " sec"}, int'(sec), m_sec);
    check({tag, " min"}, int'(min), m_min);
    check({tag, " hour"}, int'(hour), m_hour);
    check({tag, " day"}, int'(day), m_day);
    check({tag, " month"}, int'(month), m_month);
    check({tag, " year"}, int'(year), m_year);
    check({tag, " wday"}, int'(wday), m_wday);
    check({tag, " frozen"}, int'(frozen), int'(m_frozen));
  endtask

  task automatic cyc(input bit t, input bit w, input int s, input int d, input string tag);
    @(negedge clk);
    tick = t; wr_en = w; wr_sel = 3'(s); wr_data = 7'(d);
    @(posedge clk);
    #1;
    model_step(t, w, s, d);
    compare_all(tag);
  endtask

  task automatic set_all(input int s, input int mi, input int h, input int dd,
                         input int mo, input int y, input int wd);
    cyc(0, 1, 0, s, "R3 load");
    cyc(0, 1, 1, mi, "R3 load");
    cyc(0, 1, 2, h, "R3 load");
    cyc(0, 1, 3, dd, "R3 load");
    cyc(0, 1, 4, mo, "R3 load");
    cyc(0, 1, 5, y, "R3 load");
    cyc(0, 1, 6, wd, "R3 load");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_month = 1;
    m_year = 0; m_wday = 0; m_frozen = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    compare_all("R1 reset");

    // R2: ticks while frozen
    for (int i = 0; i < 5; i++) cyc(1, 0, 7, 0, "R2 frozen tick");
    // R10: select 7 ignored, frozen stays
    cyc(0, 1, 7, 55, "R10 sel none");
    check("R10 frozen kept", int'(frozen), 1);
    // R3: write with tick on same cycle while frozen does not advance
    cyc(1, 1, 0, 10, "R3 release");
    check("R3 sec loaded", int'(sec), 10);
    cyc(1, 0, 7, 0, "R3 first count");
    check("R3 counts", int'(sec), 11);

    // R4 R7 R8: full rollover
    set_all(59, 59, 23, 31, 12, 99, 6);
    cyc(1, 0, 7, 0, "R7 rollover");
    check("R7 year wrap", int'(year), 0);
    check("R8 wday wrap", int'(wday), 0);
    check("R4 hour wrap", int'(hour), 0);

    // R6: non-leap year 3
    set_all(59, 59, 23, 28, 2, 3, 2);
    cyc(1, 0, 7, 0, "R6 feb nonleap");
    check("R6 mar1", int'(month), 3);
    // R6: leap year 4
    set_all(59, 59, 23, 28, 2, 4, 2);
    cyc(1, 0, 7, 0, "R6 feb leap");
    check("R6 feb29", int'(day), 29);
    // R6: year 0 is leap
    set_all(59, 59, 23, 28, 2, 0, 2);
    cyc(1, 0, 7, 0, "R6 year0");
    check("R6 year0 feb29", int'(day), 29);
    cyc(1, 0, 7, 0, "R6 year0");
    // R5: 30-day month
    set_all(59, 59, 23, 30, 4, 21, 1);
    cyc(1, 0, 7, 0, "R5 apr30");
    check("R5 may1", int'(month), 5);
    check("R5 day1", int'(day), 1);

    // R9: write seconds on a carrying tick
    set_all(59, 10, 5, 5, 5, 5, 5);
    cyc(1, 1, 0, 30, "R9 collide");
    check("R9 sec written", int'(sec), 30);
    check("R9 min carried", int'(min), 11);
    // R9: write minutes while seconds carry into it
    cyc(0, 1, 0, 59, "R9 prep");
    cyc(1, 1, 1, 40, "R9 collide min");
    check("R9 min written", int'(min), 40);
    check("R9 sec wrapped", int'(sec), 0);

    // random mix, R4 R5 R9 R10
    for (int i = 0; i < 4000; i++) begin
      int t, w, s, d;
      t = ($urandom % 2);
      w = (($urandom % 6) == 0);
      s = $urandom % 8;
      case (s)
        0, 1: d = 50 + ($urandom % 10);
        2: d = 20 + ($urandom % 4);
        3: d = 26 + ($urandom % 6);
        4: d = 1 + ($urandom % 12);
        5: d = $urandom % 100;
        6: d = $urandom % 7;
        default: d = $urandom % 128;
      endcase
      cyc(t[0], w[0], s, d, "R9 random");
    end
    check("R4 state sanity", pack_state() & 63, int'(sec));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule